// File: doc/BRIEF.md
# ISA Bus Command Strobe Generator

This block turns one internal bus-cycle request into the control strobes of an ISA expansion bus. A request gives a cycle kind, a 24-bit address and a flag for the upper byte lane. The block accepts the request and latches it. It then runs a fixed sequence. First comes a one-clock address-latch phase. Next, the selected command strobe is driven low for a set number of clocks. Then a release clock raises a done pulse back to the requester, and the block returns to idle. All strobes are active low and idle high.

The system-memory strobes are qualified copies of the memory strobes. They fire only when the address lies in the first megabyte. The read copy also fires on a refresh cycle. During refresh and DMA cycles the address-latch strobe stays high for the whole cycle. It also stays high whenever an add-on card has taken the bus. While such a card owns the bus, the output enable for the bidirectional command and byte-high strobes is withdrawn, and no new request is accepted. The 16-bit chip-select input is sampled on memory cycles to report whether the cycle was 16-bit or 8-bit. On I/O and refresh cycles the block ignores it.

The controller has four states. ST_IDLE moves to ST_ALE when a request with a valid kind arrives and the card-ownership input is high. ST_ALE always moves to ST_CMD after one clock. ST_CMD stays for CMD_CYCLES clocks and then moves to ST_DONE. ST_DONE always moves back to ST_IDLE.

Top module: `isa_strobe_gen`

## Requirements
- R1: After reset, with `master_n` high, `ale` is 0, every strobe output is 1, and `busy`, `done` and `size16` are 0.
- R2: A request with `req_valid`=1, a kind other than 7 and `master_n`=1, seen in idle at a clock edge, starts a cycle. The cycle has one clock with `ale`=1 and the command strobes high. Then the command strobe is low for CMD_CYCLES clocks (default 3). Then comes one clock with `done`=1 and the strobes high. Then the block is idle with `busy`=0. `busy` is 1 from the address-latch clock through the done clock.
- R3: Kind encodings are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 refresh, 5 DMA read and 6 DMA write. Kinds 0, 4 and 5 drive `memr_n`. Kinds 1 and 6 drive `memw_n`. Kind 2 drives `ior_n` and kind 3 drives `iow_n`. At most one of these four is low at any time.
- R4: `smemr_n` is low only in the command phase of a refresh cycle, or of a kind 0 or 5 cycle whose address bits 23..20 are all zero.
- R5: `smemw_n` is low only in the command phase of a kind 1 or 6 cycle whose address bits 23..20 are all zero. It is never low on a refresh cycle.
- R6: For kinds 4, 5 and 6, `ale` is 1 from the address-latch clock through the done clock. For the other kinds, `ale` is 1 only in the address-latch clock. `ale` is 1 whenever `master_n` is 0.
- R7: While `master_n` is 0, `cmd_oe` is 0 and no request is accepted. While `master_n` is 1, `cmd_oe` is 1.
- R8: During the done clock of a kind 0, 1, 5 or 6 cycle, `size16` is 1 if `mcs16_n` was 0 at the clock edge that ends the address-latch phase, and 0 otherwise. On kinds 2, 3 and 4, `size16` is 0 whatever `mcs16_n` is.
- R9: `bhe_n` is low in the address-latch and command phases of a cycle whose byte-high flag is 1, unless the kind is refresh. Otherwise it is high.
- R10: A request made while a cycle is running has no effect on that cycle. A request of kind 7 starts nothing, so `busy` stays 0 and `ale` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind (encoding in R3, 7 reserved) |
| req_addr | input | 24 | Cycle address |
| req_hi_byte | input | 1 | Transfer uses the upper byte lane |
| master_n | input | 1 | Add-on card owns the bus, active low |
| mcs16_n | input | 1 | 16-bit memory chip select, active low |
| ale | output | 1 | Address latch enable |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| smemr_n | output | 1 | First-megabyte memory read strobe |
| smemw_n | output | 1 | First-megabyte memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| bhe_n | output | 1 | Byte-high enable |
| cmd_oe | output | 1 | Output enable for memr_n, memw_n, ior_n, iow_n, bhe_n |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock cycle-complete pulse |
| size16 | output | 1 | Completed memory cycle was 16-bit |

## Verification
Some properties are checked on every clock by assertions:
- at most one command strobe is low at a time;
- a system-memory strobe is never low unless its plain memory strobe is low;
- a refresh never lowers the system-memory write strobe;
- the done pulse lasts one clock and always follows the command phase;
- the command counter stays in range;
- no cycle starts while the card owns the bus.

The exact phase lengths, the first-megabyte boundary, the hold of the address-latch strobe on refresh and DMA cycles, the sampling moment of the chip select, and the rejection of reserved and overlapping requests are shown only by the bench scenarios. Each of those scenarios compares the outputs with a model on each clock of the cycle.

// File: rtl/isa_strobe_pkg.sv
package isa_strobe_pkg;

    typedef enum logic [2:0] {
        CK_MEM_RD = 3'd0,
        CK_MEM_WR = 3'd1,
        CK_IO_RD  = 3'd2,
        CK_IO_WR  = 3'd3,
        CK_REFR   = 3'd4,
        CK_DMA_RD = 3'd5,
        CK_DMA_WR = 3'd6,
        CK_RSVD   = 3'd7
    } cyc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALE  = 2'd1,
        ST_CMD  = 2'd2,
        ST_DONE = 2'd3
    } cyc_state_t;

    function automatic logic kind_is_mem(cyc_kind_t k);
        return (k == CK_MEM_RD) || (k == CK_MEM_WR) ||
               (k == CK_DMA_RD) || (k == CK_DMA_WR);
    endfunction

    function automatic logic kind_holds_ale(cyc_kind_t k);
        return (k == CK_REFR) || (k == CK_DMA_RD) || (k == CK_DMA_WR);
    endfunction

endpackage

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
    import isa_strobe_pkg::*;
#(
    parameter int CMD_CYCLES = 3,
    parameter int ADDR_W     = 24,
    parameter int MEG_BIT    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  cyc_kind_t         req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_hi_byte,
    input  logic              master_n,
    input  logic              mcs16_n,
    output cyc_state_t        state,
    output cyc_kind_t         kind_q,
    output logic              low_meg_q,
    output logic              hi_q,
    output logic              size16_q
);

    localparam int CNT_W = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_CYCLES - 1);
    localparam logic [ADDR_W:0]  MEG_LIMIT = (ADDR_W + 1)'(1) << MEG_BIT;

    cyc_state_t       state_nx;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             cmd_last;

    assign accept   = (state == ST_IDLE) && req_valid && master_n &&
                      (req_kind != CK_RSVD);
    assign cmd_last = (cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)   state_nx = ST_ALE;
            ST_ALE:                state_nx = ST_CMD;
            ST_CMD:  if (cmd_last) state_nx = ST_DONE;
            ST_DONE:               state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= CK_MEM_RD;
            low_meg_q <= 1'b0;
            hi_q      <= 1'b0;
            size16_q  <= 1'b0;
            cnt       <= '0;
        end else begin
            if (accept) begin
                kind_q    <= req_kind;
                low_meg_q <= ({1'b0, req_addr} < MEG_LIMIT);
                hi_q      <= req_hi_byte;
                size16_q  <= 1'b0;
            end
            if (state == ST_ALE) begin
                size16_q <= kind_is_mem(kind_q) && !mcs16_n;
                cnt      <= '0;
            end else if (state == ST_CMD && !cmd_last) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> (cnt <= CNT_LAST));

    // R2
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> ($past(state) == ST_CMD));

    // R7
    no_start_when_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !master_n) |=> (state == ST_IDLE));

endmodule

// File: rtl/isa_strobe_decode.sv
module isa_strobe_decode
    import isa_strobe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cyc_state_t state,
    input  cyc_kind_t  kind_q,
    input  logic       low_meg_q,
    input  logic       hi_q,
    input  logic       master_n,
    output logic       ale,
    output logic       memr_n,
    output logic       memw_n,
    output logic       smemr_n,
    output logic       smemw_n,
    output logic       ior_n,
    output logic       iow_n,
    output logic       bhe_n,
    output logic       cmd_oe,
    output logic       busy,
    output logic       done
);

    always_comb begin
        ale     = !master_n;
        memr_n  = 1'b1;
        memw_n  = 1'b1;
        smemr_n = 1'b1;
        smemw_n = 1'b1;
        ior_n   = 1'b1;
        iow_n   = 1'b1;
        bhe_n   = 1'b1;
        cmd_oe  = master_n;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_ALE: begin
                ale   = 1'b1;
                bhe_n = !(hi_q && kind_q != CK_REFR);
            end
            ST_CMD: begin
                if (kind_holds_ale(kind_q)) ale = 1'b1;
                bhe_n = !(hi_q && kind_q != CK_REFR);
                unique case (kind_q)
                    CK_MEM_RD, CK_DMA_RD: begin
                        memr_n  = 1'b0;
                        smemr_n = !low_meg_q;
                    end
                    CK_REFR: begin
                        memr_n  = 1'b0;
                        smemr_n = 1'b0;
                    end
                    CK_MEM_WR, CK_DMA_WR: begin
                        memw_n  = 1'b0;
                        smemw_n = !low_meg_q;
                    end
                    CK_IO_RD: ior_n = 1'b0;
                    CK_IO_WR: iow_n = 1'b0;
                    CK_RSVD:  ;
                endcase
            end
            ST_DONE: begin
                if (kind_holds_ale(kind_q)) ale = 1'b1;
                done = 1'b1;
            end
        endcase
    end

    // R3
    onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~memr_n, ~memw_n, ~ior_n, ~iow_n}));

    // R4
    smemr_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smemr_n |-> !memr_n);

    // R5
    smemw_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smemw_n |-> !memw_n);

    // R5
    refr_no_smemw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == CK_REFR) |-> smemw_n);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
    import isa_strobe_pkg::*;
#(
    parameter int CMD_CYCLES = 3,
    parameter int ADDR_W     = 24,
    parameter int MEG_BIT    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_hi_byte,
    input  logic              master_n,
    input  logic              mcs16_n,
    output logic              ale,
    output logic              memr_n,
    output logic              memw_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              bhe_n,
    output logic              cmd_oe,
    output logic              busy,
    output logic              done,
    output logic              size16
);

    cyc_state_t state;
    cyc_kind_t  kind_q;
    logic       low_meg_q;
    logic       hi_q;

    isa_cycle_fsm #(
        .CMD_CYCLES (CMD_CYCLES),
        .ADDR_W     (ADDR_W),
        .MEG_BIT    (MEG_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (cyc_kind_t'(req_kind)),
        .req_addr    (req_addr),
        .req_hi_byte (req_hi_byte),
        .master_n    (master_n),
        .mcs16_n     (mcs16_n),
        .state       (state),
        .kind_q      (kind_q),
        .low_meg_q   (low_meg_q),
        .hi_q        (hi_q),
        .size16_q    (size16)
    );

    isa_strobe_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .kind_q    (kind_q),
        .low_meg_q (low_meg_q),
        .hi_q      (hi_q),
        .master_n  (master_n),
        .ale       (ale),
        .memr_n    (memr_n),
        .memw_n    (memw_n),
        .smemr_n   (smemr_n),
        .smemw_n   (smemw_n),
        .ior_n     (ior_n),
        .iow_n     (iow_n),
        .bhe_n     (bhe_n),
        .cmd_oe    (cmd_oe),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: tb/isa_strobe_gen_bench.sv
`timescale 1ns/1ps
module isa_strobe_gen_bench;

    localparam int CMDC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [23:0] req_addr = '0;
    logic        req_hi_byte = 1'b0;
    logic        master_n = 1'b1;
    logic        mcs16_n = 1'b1;
    logic ale, memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n, bhe_n;
    logic cmd_oe, busy, done, size16;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    isa_strobe_gen #(.CMD_CYCLES(CMDC)) u_isa_strobe_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_hi_byte(req_hi_byte), .master_n(master_n),
        .mcs16_n(mcs16_n), .ale(ale), .memr_n(memr_n), .memw_n(memw_n),
        .smemr_n(smemr_n), .smemw_n(smemw_n), .ior_n(ior_n), .iow_n(iow_n),
        .bhe_n(bhe_n), .cmd_oe(cmd_oe), .busy(busy), .done(done), .size16(size16)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {memr_n, memw_n, ior_n, iow_n, smemr_n, smemw_n} during command phase
    function automatic logic [5:0] exp_strb(logic [2:0] k, logic [23:0] a);
        logic low = (a[23:20] == 4'h0);
        case (k)
            3'd0, 3'd5: return {1'b0, 1'b1, 1'b1, 1'b1, !low, 1'b1};
            3'd4:       return {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
            3'd1, 3'd6: return {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, !low};
            3'd2:       return 6'b110111;
            3'd3:       return 6'b111011;
            default:    return 6'b111111;
        endcase
    endfunction

    function automatic logic exp_hold(logic [2:0] k);
        return (k == 3'd4) || (k == 3'd5) || (k == 3'd6);
    endfunction

    function automatic logic exp_sz(logic [2:0] k, logic m);
        return (k == 3'd0 || k == 3'd1 || k == 3'd5 || k == 3'd6) && !m;
    endfunction

    function automatic logic exp_bhe(logic [2:0] k, logic h);
        return !(h && k != 3'd4);
    endfunction

    function automatic logic [5:0] strb();
        return {memr_n, memw_n, ior_n, iow_n, smemr_n, smemw_n};
    endfunction

    task automatic run_cycle(logic [2:0] k, logic [23:0] a, logic h, logic m,
                             logic poke);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_hi_byte = h; mcs16_n = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (k == 3'd7) begin
            check("R10 reserved kind busy", busy, 0);
            check("R10 reserved kind ale", ale, 0);
            check("R10 reserved kind strobes", strb(), 6'h3f);
            return;
        end
        check("R2 ale phase ale", ale, 1);
        check("R2 ale phase strobes high", strb(), 6'h3f);
        check("R2 busy in ale phase", busy, 1);
        check("R9 bhe in ale phase", bhe_n, exp_bhe(k, h));
        if (poke) begin
            req_valid = 1'b1; req_kind = 3'd3; req_addr = 24'hFFFFFF; req_hi_byte = !h;
        end
        for (int i = 0; i < CMDC; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            check(poke ? "R10 cmd strobes unchanged" : "R3 R4 R5 cmd strobes",
                  strb(), exp_strb(k, a));
            check("R6 ale in cmd phase", ale, exp_hold(k));
            check("R9 bhe in cmd phase", bhe_n, exp_bhe(k, h));
            check("R2 done low in cmd", done, 0);
        end
        @(negedge clk);
        check("R2 done pulse", done, 1);
        check("R2 strobes released", strb(), 6'h3f);
        check("R6 ale in done", ale, exp_hold(k));
        check("R8 size16", size16, exp_sz(k, m));
        @(negedge clk);
        check("R2 back to idle busy", busy, 0);
        check("R2 done cleared", done, 0);
        check("R6 ale low in idle", ale, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ale", ale, 0);
        check("R1 strobes", {strb(), bhe_n}, 7'h7f);
        check("R1 busy done size16", {busy, done, size16}, 0);
        check("R7 cmd_oe driven", cmd_oe, 1);

        // Directed: megabyte boundary and each kind
        run_cycle(3'd0, 24'h0FFFFF, 1'b1, 1'b0, 1'b0);
        run_cycle(3'd0, 24'h100000, 1'b0, 1'b1, 1'b0);
        run_cycle(3'd1, 24'h0FFFFF, 1'b0, 1'b0, 1'b0);
        run_cycle(3'd1, 24'h100000, 1'b1, 1'b0, 1'b0);
        run_cycle(3'd4, 24'hF00000, 1'b1, 1'b0, 1'b0);
        run_cycle(3'd2, 24'h000300, 1'b1, 1'b0, 1'b0);
        run_cycle(3'd3, 24'h000300, 1'b0, 1'b0, 1'b0);
        run_cycle(3'd5, 24'h012345, 1'b0, 1'b0, 1'b0);
        run_cycle(3'd6, 24'h812345, 1'b1, 1'b1, 1'b0);
        run_cycle(3'd7, 24'h000000, 1'b0, 1'b0, 1'b0);
        run_cycle(3'd0, 24'h000010, 1'b0, 1'b1, 1'b1);

        // R7: card owns the bus
        @(negedge clk);
        master_n = 1'b0; req_valid = 1'b1; req_kind = 3'd0; req_addr = 24'h0;
        @(negedge clk);
        check("R7 cmd_oe withdrawn", cmd_oe, 0);
        check("R6 ale high while owned", ale, 1);
        check("R7 no accept while owned", busy, 0);
        @(negedge clk);
        check("R7 still idle while owned", {busy, strb()}, 7'h3f);
        master_n = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        check("R7 cmd_oe restored", cmd_oe, 1);
        check("R7 idle after release", {busy, ale}, 0);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic [2:0]  k = 3'($urandom % 8);
            logic [23:0] a = 24'($urandom);
            if ($urandom % 2 == 0) a[23:20] = 4'h0;
            run_cycle(k, a, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule